// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a general-purpose timer. It holds a 16-bit up-counter and one compare register. The counter is fed by a prescaled version of the system clock. A programmable divider and an edge-select field decide which cycles produce a count. An encoded field in the control byte decides whether the counter returns to zero after it reaches the compare value, which gives a periodic tick of compare+1 counts.

Each time the counter reaches the compare value, the block does three things. It raises a sticky match flag. It can drive an interrupt request. It applies a programmed action (clear, set or toggle) to a compare output pin. Software clears the flag by reading it as set and then writing it back as zero.

Run control sits in a start register shared by several channels, one bit per channel. A channel counts only while its own bit is high. The usual sequence is: stop the channel, program the control, I/O-control, compare and counter registers, then set its start bit.

Top module: `cmt_channel`

## Requirements
- R1: After reset every register reads 0, the start register reads 0, the compare pin is 0 and the interrupt request is 0.
- R2: Registers sit at these offsets from the channel base: control 0, mode 1, I/O control 2, interrupt enable 4, status 5, counter 6, compare 8. The shared start register is at 0x280. The 8-bit registers read back the low byte written to them. The counter and compare registers read back all 16 bits. The start register reads back its NUM_CH bits.
- R3: The counter changes only on a counting tick while start bit CH_IDX (bit 0 by default) is 1, or on a bus write to the counter. Other start bits have no effect on this channel.
- R4: Control bits 2:0 pick the divider: 0, 1, 2, 3 give N = 1, 4, 16, 64, and values 4 to 7 give no ticks at all. Let c be the running-cycle index, counted from 0 at the cycle after the start bit is set. With N = 1 every running cycle ticks. Otherwise control bits 4:3 pick the edge: 0 (rising) ticks when c mod N = N/2-1; 1 (falling) ticks when c mod N = N-1; 2 or 3 (both) ticks when c mod (N/2) = N/2-1.
- R5: Control bits 7:5 set to 1 make the counter return to 0 on the tick after it equals the compare value, so the period is compare+1 ticks. Every other value lets the counter run freely and wrap from 0xFFFF to 0.
- R6: Status bit 0 is set at the edge where a tick moves the counter to the compare value. A bus write that loads the counter with the compare value does not set it.
- R7: Status bit 0 clears only on a status write with bit 0 at 0 that follows a status read returning bit 0 as 1. Any status write uses up that read. A write with bit 0 at 1, or a write with no prior read, leaves the flag set. A match on the same edge as a clearing write keeps the flag set.
- R8: The interrupt request is high exactly when status bit 0 and interrupt-enable bit 0 are both 1.
- R9: A write to I/O control sets the pin from the new low nibble: 1, 2 or 3 drive it to 0; 5, 6 or 7 drive it to 1; any other value leaves it unchanged.
- R10: On each match the pin follows the stored low nibble: 1 or 5 clear it, 2 or 6 set it, 3 or 7 toggle it, and any other value leaves it unchanged.
- R11: The prescaler phase restarts each time start bit CH_IDX goes from 0 to 1, so c in R4 counts from 0 again in every run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read strobe, used by the flag-acknowledge rule |
| bus_wdata | input | CNT_W | Write data (8-bit registers take the low byte) |
| bus_rdata | output | CNT_W | Read data for the current address, combinational |
| cmp_out | output | 1 | Compare output pin |
| irq_out | output | 1 | Match interrupt request |

## Verification
The divider and edge fields are swept over every combination and every unused divider code, each with a short and a long run. The expected count comes from the modular rule, so a wrong tap or a wrong edge phase shows up as a different count. Periodic runs use compare values that end mid-period, and a wrap run starts near 0xFFFF. Together they separate clear-on-match from free running, and the code-2 run shows that other clear codes do not clear. Output actions are swept over all eight codes with a run that gives an odd number of matches, so toggle differs from retain. A compare value of 0 makes a match fall on the same edge as the clearing write. A stop-and-restart run places the second tick where it lands only if the prescaler phase restarts.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
   localparam int OFS_CTRL  = 0;
   localparam int OFS_MODE  = 1;
   localparam int OFS_IOCTL = 2;
   localparam int OFS_IEN   = 4;
   localparam int OFS_STAT  = 5;
   localparam int OFS_CNT   = 6;
   localparam int OFS_CMP   = 8;

   localparam logic [2:0] CLR_ON_A = 3'd1;

   typedef enum logic [1:0] {
      EDGE_RISE  = 2'd0,
      EDGE_FALL  = 2'd1,
      EDGE_BOTH  = 2'd2,
      EDGE_BOTH2 = 2'd3
   } edge_e;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler import cmt_pkg::*; #(
   parameter int NUM_PSC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] psc_sel,
   input  logic [1:0] edge_sel,
   output logic       tick
);
   localparam int PRE_W = 2 * (NUM_PSC - 1);

   initial assert (NUM_PSC >= 2 && NUM_PSC <= 8)
      else $error("cmt_prescaler: NUM_PSC must be 2..8");

   logic [PRE_W-1:0]   pre;
   logic [NUM_PSC-1:0] tap_tick;
   logic [7:0]         tap_all;

   always_ff @(posedge clk) begin
      if (!rst_n)   pre <= '0;
      else if (!run) pre <= '0;
      else          pre <= pre + 1'b1;
   end

   assign tap_tick[0] = 1'b1;

   for (genvar gi = 1; gi < NUM_PSC; gi++) begin : g_tap
      localparam int K = 2 * gi - 1;
      logic [K:0] low;
      logic       t_g;
      assign low = pre[K:0];
      always_comb begin
         if (edge_sel == EDGE_RISE)      t_g = (low == {1'b0, {K{1'b1}}});
         else if (edge_sel == EDGE_FALL) t_g = &low;
         else                            t_g = &low[K-1:0];
      end
      assign tap_tick[gi] = t_g;
   end

   assign tap_all = 8'(tap_tick);
   assign tick    = run & tap_all[psc_sel];

   // R11
   pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> pre == '0);
   // R4
   no_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(psc_sel) >= NUM_PSC) |-> !tick);
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr_on_a,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] wdata,
   input  logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] cnt,
   output logic             match_evt
);
   logic [CNT_W-1:0] nxt;

   assign nxt       = (clr_on_a && cnt == cmp_val) ? '0 : cnt + 1'b1;
   assign match_evt = tick && !cnt_we && (nxt == cmp_val);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (cnt_we) cnt <= wdata;
      else if (tick)   cnt <= nxt;
   end

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !cnt_we |=> $stable(cnt));
   // R5
   bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_on_a && !cnt_we && cnt <= cmp_val |=> cnt <= $past(cmp_val));
endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic stat_rd,
   input  logic stat_we,
   input  logic wbit0,
   input  logic match_evt,
   output logic flag
);
   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else begin
         if (match_evt)                        flag <= 1'b1;
         else if (stat_we && !wbit0 && armed)  flag <= 1'b0;
         if (stat_we)                          armed <= 1'b0;
         else if (stat_rd && flag)             armed <= 1'b1;
      end
   end

   // R7
   ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !armed |=> flag);
   // R6
   set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> flag);
endmodule

// File: rtl/cmt_outpin.sv
module cmt_outpin (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       io_we,
   input  logic [3:0] new_act,
   input  logic [3:0] act,
   input  logic       match_evt,
   output logic       pin
);
   always_ff @(posedge clk) begin
      if (!rst_n) pin <= 1'b0;
      else if (io_we) begin
         case (new_act)
            4'd1, 4'd2, 4'd3: pin <= 1'b0;
            4'd5, 4'd6, 4'd7: pin <= 1'b1;
            default:          pin <= pin;
         endcase
      end else if (match_evt) begin
         case (act)
            4'd1, 4'd5: pin <= 1'b0;
            4'd2, 4'd6: pin <= 1'b1;
            4'd3, 4'd7: pin <= ~pin;
            default:    pin <= pin;
         endcase
      end
   end

   // R10
   toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt && !io_we && act[1:0] == 2'b11 && !act[3] |=> pin != $past(pin));
   // R9
   init_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_we && !new_act[3] && !new_act[2] && new_act[1:0] != 2'b00 |=> !pin);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel import cmt_pkg::*; #(
   parameter int ADDR_W     = 10,
   parameter int CNT_W      = 16,
   parameter int NUM_CH     = 3,
   parameter int CH_IDX     = 0,
   parameter int NUM_PSC    = 4,
   parameter int CH_BASE    = 0,
   parameter int START_ADDR = 'h280
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              cmp_out,
   output logic              irq_out
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CH_BASE + OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(CH_BASE + OFS_MODE);
   localparam logic [ADDR_W-1:0] A_IOCTL = ADDR_W'(CH_BASE + OFS_IOCTL);
   localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(CH_BASE + OFS_IEN);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(CH_BASE + OFS_STAT);
   localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(CH_BASE + OFS_CNT);
   localparam logic [ADDR_W-1:0] A_CMP   = ADDR_W'(CH_BASE + OFS_CMP);
   localparam logic [ADDR_W-1:0] A_START = ADDR_W'(START_ADDR);

   initial begin
      assert (CNT_W >= 8) else $error("cmt_channel: CNT_W below 8");
      assert (NUM_CH >= 1 && NUM_CH <= CNT_W) else $error("cmt_channel: NUM_CH out of range");
      assert (CH_IDX >= 0 && CH_IDX < NUM_CH) else $error("cmt_channel: CH_IDX out of range");
      assert (START_ADDR < (1 << ADDR_W)) else $error("cmt_channel: START_ADDR too wide");
   end

   logic [7:0]        ctrl_q, mode_q, ioctl_q, ien_q;
   logic [CNT_W-1:0]  cmp_q, cnt;
   logic [NUM_CH-1:0] start_q;
   logic              tick, match_evt, flag, run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         mode_q  <= '0;
         ioctl_q <= '0;
         ien_q   <= '0;
         cmp_q   <= '0;
         start_q <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            A_CTRL:  ctrl_q  <= bus_wdata[7:0];
            A_MODE:  mode_q  <= bus_wdata[7:0];
            A_IOCTL: ioctl_q <= bus_wdata[7:0];
            A_IEN:   ien_q   <= bus_wdata[7:0];
            A_CMP:   cmp_q   <= bus_wdata;
            A_START: start_q <= bus_wdata[NUM_CH-1:0];
            default: ;
         endcase
      end
   end

   assign run = start_q[CH_IDX];

   cmt_prescaler #(.NUM_PSC(NUM_PSC)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(run),
      .psc_sel(ctrl_q[2:0]), .edge_sel(ctrl_q[4:3]), .tick(tick));

   cmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .clr_on_a(ctrl_q[7:5] == CLR_ON_A),
      .cnt_we(bus_wr && bus_addr == A_CNT), .wdata(bus_wdata),
      .cmp_val(cmp_q), .cnt(cnt), .match_evt(match_evt));

   cmt_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .stat_rd(bus_rd && bus_addr == A_STAT),
      .stat_we(bus_wr && bus_addr == A_STAT),
      .wbit0(bus_wdata[0]), .match_evt(match_evt), .flag(flag));

   cmt_outpin u_pin (
      .clk(clk), .rst_n(rst_n),
      .io_we(bus_wr && bus_addr == A_IOCTL), .new_act(bus_wdata[3:0]),
      .act(ioctl_q[3:0]), .match_evt(match_evt), .pin(cmp_out));

   assign irq_out = flag & ien_q[0];

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = CNT_W'(ctrl_q);
         A_MODE:  bus_rdata = CNT_W'(mode_q);
         A_IOCTL: bus_rdata = CNT_W'(ioctl_q);
         A_IEN:   bus_rdata = CNT_W'(ien_q);
         A_STAT:  bus_rdata = CNT_W'(flag);
         A_CNT:   bus_rdata = cnt;
         A_CMP:   bus_rdata = cmp_q;
         A_START: bus_rdata = CNT_W'(start_q);
         default: bus_rdata = '0;
      endcase
   end

   // R3
   stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);
endmodule

// File: tb/sim_cmt_channel.sv
module sim_cmt_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        cmp_out, irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [9:0] R_CTRL = 10'h000, R_MODE = 10'h001, R_IOCTL = 10'h002,
      R_IEN = 10'h004, R_STAT = 10'h005, R_CNT = 10'h006, R_CMP = 10'h008,
      R_START = 10'h280;

   always #5 clk = ~clk;

   cmt_channel u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cmp_out(cmp_out), .irq_out(irq_out));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output int d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = int'(bus_rdata);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   // Expected tick count over m running cycles (R4 rule)
   function automatic int ticks(input int psc, input int edg, input int m);
      int n, t;
      t = 0;
      if (psc > 3) return 0;
      n = 1 << (2 * psc);
      for (int c = 0; c < m; c++) begin
         if (n == 1) t++;
         else if (edg == 0 && c % n == n/2 - 1) t++;
         else if (edg == 1 && c % n == n - 1) t++;
         else if (edg >= 2 && c % (n/2) == n/2 - 1) t++;
      end
      return t;
   endfunction

   // start, idle k, stop: the counter sees k+2 running cycles
   task automatic run_for(input int k);
      wr(R_START, 16'h0001);
      idle(k);
      wr(R_START, 16'h0000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int v, exp_pin, init_pin;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(R_CTRL, v);  chk("R1", "ctrl", v, 0);
      rd(R_MODE, v);  chk("R1", "mode", v, 0);
      rd(R_IOCTL, v); chk("R1", "ioctl", v, 0);
      rd(R_IEN, v);   chk("R1", "ien", v, 0);
      rd(R_STAT, v);  chk("R1", "stat", v, 0);
      rd(R_CNT, v);   chk("R1", "cnt", v, 0);
      rd(R_CMP, v);   chk("R1", "cmp", v, 0);
      rd(R_START, v); chk("R1", "start", v, 0);
      chk("R1", "pin", int'(cmp_out), 0);
      chk("R1", "irq", int'(irq_out), 0);

      // R2 readback
      wr(R_CTRL, 16'h12A5);  rd(R_CTRL, v);  chk("R2", "ctrl", v, 'hA5);
      wr(R_MODE, 16'h003C);  rd(R_MODE, v);  chk("R2", "mode", v, 'h3C);
      wr(R_IOCTL, 16'h0070); rd(R_IOCTL, v); chk("R2", "ioctl", v, 'h70);
      wr(R_IEN, 16'h0080);   rd(R_IEN, v);   chk("R2", "ien", v, 'h80);
      wr(R_CMP, 16'hBEEF);   rd(R_CMP, v);   chk("R2", "cmp", v, 'hBEEF);
      wr(R_CTRL, 16'h0000);
      wr(R_CNT, 16'hBEEF);   rd(R_CNT, v);   chk("R2", "cnt", v, 'hBEEF);
      // R3 other channels' start bits do not run this one
      wr(R_START, 16'h0006); rd(R_START, v); chk("R2", "start", v, 6);
      idle(10);
      rd(R_CNT, v); chk("R3", "cnt with own bit 0", v, 'hBEEF);
      wr(R_START, 16'h0000); wr(R_MODE, 0); wr(R_IOCTL, 0); wr(R_IEN, 0);

      // R6 loading counter with compare value does not flag
      wr(R_CMP, 5); wr(R_CNT, 5);
      rd(R_STAT, v); chk("R6", "flag after cnt load", v, 0);

      // R6 flag set exactly when counting reaches compare
      wr(R_CMP, 3); wr(R_CNT, 0); run_for(0);
      rd(R_CNT, v);  chk("R6", "cnt after 2", v, 2);
      rd(R_STAT, v); chk("R6", "flag before match", v, 0);
      wr(R_CNT, 0); run_for(1);
      rd(R_CNT, v);  chk("R6", "cnt after 3", v, 3);

      // R7 acknowledge protocol (flag set, not yet read)
      wr(R_STAT, 0);
      rd(R_STAT, v); chk("R7", "write 0 without read", v, 1);
      wr(R_STAT, 1);
      rd(R_STAT, v); chk("R7", "write 1 after read", v, 1);
      // R8 interrupt gating
      chk("R8", "irq with ien 0", int'(irq_out), 0);
      wr(R_IEN, 1);
      chk("R8", "irq with ien 1", int'(irq_out), 1);
      wr(R_STAT, 0);
      rd(R_STAT, v); chk("R7", "read then write 0", v, 0);
      chk("R8", "irq after ack", int'(irq_out), 0);

      // R7 set wins: compare 0 with clear-on-A matches on every tick
      wr(R_CMP, 0); wr(R_CNT, 0); wr(R_CTRL, 16'h0020);
      wr(R_START, 1);
      rd(R_STAT, v); chk("R7", "flag while matching", v, 1);
      wr(R_STAT, 0);
      wr(R_START, 0);
      rd(R_STAT, v); chk("R7", "set wins over clear", v, 1);
      wr(R_STAT, 0);
      rd(R_STAT, v); chk("R7", "clear after stop", v, 0);
      wr(R_IEN, 0);

      // R4 divider and edge sweep, free running
      for (int psc = 0; psc < 8; psc++) begin
         for (int edg = 0; edg < 4; edg++) begin
            for (int kk = 0; kk < 2; kk++) begin
               int k;
               k = (kk == 0) ? 3 : 37;
               if (psc > 3 && (edg > 0 || kk > 0)) continue;
               wr(R_CTRL, 16'((edg << 3) | psc));
               wr(R_CNT, 0);
               run_for(k);
               rd(R_CNT, v);
               chk("R4", $sformatf("psc %0d edge %0d k %0d", psc, edg, k), v, ticks(psc, edg, k + 2));
            end
         end
      end

      // R5 periodic clear on A
      wr(R_CMP, 4); wr(R_CTRL, 16'h0020); wr(R_CNT, 0);
      run_for(20);
      rd(R_CNT, v); chk("R5", "periodic count", v, 22 % 5);
      rd(R_STAT, v); chk("R6", "flag after periodic", v, 1);
      wr(R_STAT, 0);
      // R5 free-run wrap
      wr(R_CTRL, 16'h0000); wr(R_CNT, 16'hFFFE);
      run_for(1);
      rd(R_CNT, v); chk("R5", "wrap", v, 1);
      // R5 clear code 2 behaves as never clear
      wr(R_CTRL, 16'h0040); wr(R_CMP, 1); wr(R_CNT, 0);
      run_for(8);
      rd(R_CNT, v); chk("R5", "code 2 no clear", v, 10);
      rd(R_STAT, v); wr(R_STAT, 0);

      // R9 / R10 output actions: compare 2, clear on A, 9 cycles -> 3 matches
      for (int act = 0; act < 13; act++) begin
         if (act > 7 && act != 12) continue;
         wr(R_IOCTL, 5);
         wr(R_IOCTL, 16'(act));
         init_pin = (act >= 1 && act <= 3) ? 0 : 1;
         chk("R9", $sformatf("init act %0d", act), int'(cmp_out), init_pin);
         wr(R_CMP, 2); wr(R_CTRL, 16'h0020); wr(R_CNT, 0);
         run_for(7);
         case (act)
            1, 5: exp_pin = 0;
            2, 6: exp_pin = 1;
            3, 7: exp_pin = 1 - init_pin;
            default: exp_pin = init_pin;
         endcase
         chk("R10", $sformatf("after 3 matches act %0d", act), int'(cmp_out), exp_pin);
      end

      // R11 prescaler restart: div16 rising, two runs of 8 cycles each
      wr(R_CTRL, 16'h0002); wr(R_CNT, 0);
      run_for(6);
      run_for(6);
      rd(R_CNT, v); chk("R11", "two restarted runs", v, 2 * ticks(2, 0, 8));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule